// File: doc/BRIEF.md
# Light Sample Decoder with Checksum

This block accepts one light measurement as a pair of 16-bit words from an ambient light sensor. It splits the pair into a 4-bit exponent, a 20-bit mantissa, a 4-bit rolling sample counter and a 4-bit received checksum. It recomputes the checksum from the exponent, mantissa and counter, and flags a mismatch. When the checksum matches, the block expands the mantissa by the exponent, as a floating-point value would be, and multiplies the result by a scale constant for the sensor package. The result is a 64-bit raw lux product. Downstream logic divides that product to reach physical units.

A small controller moves each accepted pair through four named states. `ST_IDLE` holds `in_ready` high. The transition `ST_IDLE -> ST_CHECK` occurs on a handshake (`in_valid` with `in_ready`), and the words are captured at that edge. `ST_CHECK -> ST_SCALE` always follows one cycle later, registering the mismatch flag and the shifted mantissa. `ST_SCALE -> ST_EMIT` always follows next, registering the product. `ST_EMIT -> ST_IDLE` always follows after the single output beat. Without a handshake, `ST_IDLE` stays in `ST_IDLE`. The `pkg_sel` input is static and picks one of two scale constants.

Top module: `lux_frame_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Field split. The exponent is first word bits 15:12. The mantissa is first word bits 11:0 shifted left by 8, plus second word bits 15:8. The counter is second word bits 7:4. The received checksum is second word bits 3:0. The exponent, mantissa and counter appear on the output beat.
- R3: The expected checksum is computed as follows. Bit 0 is the parity of every bit of the mantissa, exponent and counter. Bit 1 is the parity of (mantissa & 0xAAAAA), (exponent & 0xA) and (counter & 0xA). Bit 2 is the parity of (mantissa & 0x88888), (exponent & 0x8) and (counter & 0x8). Bit 3 is the parity of (mantissa & 0x80808) alone. If the expected checksum equals the received one, `out_crc_err` is 0.
- R4: If the expected checksum differs from the received one, `out_crc_err` is 1 and `out_lux_raw` is 0 on that beat.
- R5: On a match, `out_lux_raw` equals (mantissa << exponent) × K. K is 4375 when `pkg_sel` = 0 and 3125 when `pkg_sel` = 1.
- R6: Exponent 15 with mantissa 0xFFFFF produces the exact product with no loss of bits.
- R7: Each accepted pair gives exactly one `out_valid` beat, three cycles after the accepting edge. `in_ready` stays low from the accepting edge until that beat has ended.
- R8: `in_valid` and the words are ignored while `in_ready` is low. A pair held during a busy period is accepted only when `ST_IDLE` returns, and it yields its own later beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word pair present |
| in_ready | output | 1 | Block can accept a pair |
| in_hi | input | 16 | First result word (exponent and upper mantissa) |
| in_lo | input | 16 | Second result word (lower mantissa, counter, checksum) |
| pkg_sel | input | 1 | Static scale constant select |
| out_valid | output | 1 | One-cycle result strobe |
| out_exp | output | 4 | Decoded exponent |
| out_mant | output | 20 | Decoded mantissa |
| out_count | output | 4 | Decoded sample counter |
| out_crc_err | output | 1 | Checksum mismatch flag |
| out_lux_raw | output | 64 | Scaled product, zero on mismatch |

## Verification
The bench builds the block with its default parameters: a 64-bit product and scale constants of 4375 and 3125. Because `pkg_sel` is a port, both constants can be exercised in a single build. With the 64-bit default, exponent 15 with a full mantissa reaches the top of the product range, which is about 2^47. Corrupting each checksum bit in turn, and a single mantissa bit, reaches every parity equation's mismatch path.

// File: rtl/lux_dec_pkg.sv
package lux_dec_pkg;
    localparam int EXP_W  = 4;
    localparam int MANT_W = 20;
    localparam int CNT_W  = 4;
    localparam int CRC_W  = 4;
    localparam int SHIFT_W = MANT_W + (1 << EXP_W) - 1;

    localparam logic [MANT_W-1:0] MANT_ODD_MASK  = 20'hAAAAA;
    localparam logic [MANT_W-1:0] MANT_NIB_MASK  = 20'h88888;
    localparam logic [MANT_W-1:0] MANT_BYTE_MASK = 20'h80808;
    localparam logic [EXP_W-1:0]  NIB_ODD_MASK   = 4'hA;
    localparam logic [EXP_W-1:0]  NIB_TOP_MASK   = 4'h8;

    typedef struct packed {
        logic [EXP_W-1:0]  exp;
        logic [MANT_W-1:0] mant;
        logic [CNT_W-1:0]  cnt;
        logic [CRC_W-1:0]  crc;
    } sample_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_SCALE = 2'd2,
        ST_EMIT  = 2'd3
    } dec_state_t;
endpackage

// File: rtl/lux_chk_gen.sv
module lux_chk_gen
    import lux_dec_pkg::*;
(
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [MANT_W-1:0] mant_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [CRC_W-1:0]  crc_o
);
    always_comb begin
        crc_o[0] = ^{mant_i, exp_i, cnt_i};
        crc_o[1] = ^{mant_i & MANT_ODD_MASK, exp_i & NIB_ODD_MASK, cnt_i & NIB_ODD_MASK};
        crc_o[2] = ^{mant_i & MANT_NIB_MASK, exp_i & NIB_TOP_MASK, cnt_i & NIB_TOP_MASK};
        crc_o[3] = ^(mant_i & MANT_BYTE_MASK);
    end
endmodule

// File: rtl/lux_decode_ctrl.sv
module lux_decode_ctrl
    import lux_dec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    output logic cap_en,
    output logic chk_en,
    output logic mul_en,
    output logic out_valid
);
    dec_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_CHECK : ST_IDLE;
            ST_CHECK: state_d = ST_SCALE;
            ST_SCALE: state_d = ST_EMIT;
            ST_EMIT:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        chk_en    = 1'b0;
        mul_en    = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  in_ready  = 1'b1;
            ST_CHECK: chk_en    = 1'b1;
            ST_SCALE: mul_en    = 1'b1;
            ST_EMIT:  out_valid = 1'b1;
            default:  in_ready  = 1'b0;
        endcase
        cap_en = in_ready & in_valid;
    end

    // R7
    emit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> (!out_valid && in_ready));
    // R7
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cap_en, 3) |-> out_valid);
    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> !in_ready);
endmodule

// File: rtl/lux_scaler.sv
module lux_scaler
    import lux_dec_pkg::*;
#(
    parameter int PROD_W  = 64,
    parameter int SCALE_A = 4375,
    parameter int SCALE_B = 3125
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en,
    input  logic              mul_en,
    input  logic              pkg_sel,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [MANT_W-1:0] mant_i,
    input  logic              mismatch_i,
    output logic              err_o,
    output logic [PROD_W-1:0] prod_o
);
    localparam logic [PROD_W-1:0] K_A = PROD_W'(SCALE_A);
    localparam logic [PROD_W-1:0] K_B = PROD_W'(SCALE_B);

    logic [SHIFT_W-1:0] shf_q;
    logic               err_q;
    logic [PROD_W-1:0]  prod_q;
    logic [PROD_W-1:0]  k_sel;

    assign k_sel = pkg_sel ? K_B : K_A;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shf_q  <= '0;
            err_q  <= 1'b0;
            prod_q <= '0;
        end else begin
            if (chk_en) begin
                shf_q <= SHIFT_W'(mant_i) << exp_i;
                err_q <= mismatch_i;
            end
            if (mul_en)
                prod_q <= err_q ? '0 : PROD_W'(shf_q) * k_sel;
        end
    end

    assign err_o  = err_q;
    assign prod_o = prod_q;

    // R6
    no_shift_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |=> ((shf_q >> $past(exp_i)) == SHIFT_W'($past(mant_i))));
endmodule

// File: rtl/lux_frame_decoder.sv
module lux_frame_decoder
    import lux_dec_pkg::*;
#(
    parameter int PROD_W  = 64,
    parameter int SCALE_A = 4375,
    parameter int SCALE_B = 3125
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [15:0]       in_hi,
    input  logic [15:0]       in_lo,
    input  logic              pkg_sel,
    output logic              out_valid,
    output logic [EXP_W-1:0]  out_exp,
    output logic [MANT_W-1:0] out_mant,
    output logic [CNT_W-1:0]  out_count,
    output logic              out_crc_err,
    output logic [PROD_W-1:0] out_lux_raw
);
    sample_t            smp_q;
    logic               cap_en, chk_en, mul_en;
    logic [CRC_W-1:0]   crc_calc;

    lux_decode_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .cap_en(cap_en), .chk_en(chk_en), .mul_en(mul_en), .out_valid(out_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else if (cap_en) begin
            smp_q.exp  <= in_hi[15:12];
            smp_q.mant <= {in_hi[11:0], in_lo[15:8]};
            smp_q.cnt  <= in_lo[7:4];
            smp_q.crc  <= in_lo[3:0];
        end
    end

    lux_chk_gen u_chk (
        .exp_i(smp_q.exp), .mant_i(smp_q.mant), .cnt_i(smp_q.cnt), .crc_o(crc_calc)
    );

    lux_scaler #(.PROD_W(PROD_W), .SCALE_A(SCALE_A), .SCALE_B(SCALE_B)) u_scale (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .mul_en(mul_en),
        .pkg_sel(pkg_sel), .exp_i(smp_q.exp), .mant_i(smp_q.mant),
        .mismatch_i(crc_calc != smp_q.crc),
        .err_o(out_crc_err), .prod_o(out_lux_raw)
    );

    assign out_exp   = smp_q.exp;
    assign out_mant  = smp_q.mant;
    assign out_count = smp_q.cnt;

    // R4
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_crc_err) |-> (out_lux_raw == '0));
    // R8
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !out_valid) |=> $stable(smp_q));
endmodule

// File: tb/lux_frame_decoder_test.sv
module lux_frame_decoder_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_hi = '0;
    logic [15:0] in_lo = '0;
    logic        pkg_sel = 1'b0;
    logic        out_valid;
    logic [3:0]  out_exp;
    logic [19:0] out_mant;
    logic [3:0]  out_count;
    logic        out_crc_err;
    logic [63:0] out_lux_raw;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lux_frame_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_hi(in_hi), .in_lo(in_lo), .pkg_sel(pkg_sel), .out_valid(out_valid),
        .out_exp(out_exp), .out_mant(out_mant), .out_count(out_count),
        .out_crc_err(out_crc_err), .out_lux_raw(out_lux_raw)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_crc(input logic [3:0] e, input logic [19:0] m,
                                           input logic [3:0] c);
        logic [3:0] r;
        r[0] = ^{m, e, c};
        r[1] = ^{m & 20'hAAAAA, e & 4'hA, c & 4'hA};
        r[2] = ^{m & 20'h88888, e & 4'h8, c & 4'h8};
        r[3] = ^(m & 20'h80808);
        return r;
    endfunction

    function automatic logic [63:0] ref_lux(input logic [3:0] e, input logic [19:0] m,
                                            input logic sel);
        logic [63:0] k;
        k = sel ? 64'd3125 : 64'd4375;
        return ({44'd0, m} << e) * k;
    endfunction

    task automatic check_beat(input logic [3:0] e, input logic [19:0] m, input logic [3:0] c,
                              input bit err, input logic [63:0] lux, input string req);
        chk(out_valid == 1'b1, "R7", "beat present", 64'(out_valid), 64'd1);
        chk(out_exp == e, "R2", {req, " exponent"}, 64'(out_exp), 64'(e));
        chk(out_mant == m, "R2", {req, " mantissa"}, 64'(out_mant), 64'(m));
        chk(out_count == c, "R2", {req, " counter"}, 64'(out_count), 64'(c));
        chk(out_crc_err == err, err ? "R4" : "R3", {req, " error flag"},
            64'(out_crc_err), 64'(err));
        chk(out_lux_raw == lux, err ? "R4" : "R5", {req, " product"}, out_lux_raw, lux);
    endtask

    // One pair through the pipeline; crc_flip / m_flip corrupt the frame after the checksum is formed
    task automatic run_sample(input logic [3:0] e, input logic [19:0] m, input logic [3:0] c,
                              input logic [3:0] crc_flip, input logic [19:0] m_flip,
                              input logic sel, input string req);
        logic [19:0] ms;
        bit          err;
        ms  = m ^ m_flip;
        err = (crc_flip != 4'd0) || (m_flip != 20'd0);
        @(negedge clk);
        chk(in_ready == 1'b1, "R7", {req, " ready before"}, 64'(in_ready), 64'd1);
        pkg_sel  = sel;
        in_valid = 1'b1;
        in_hi    = {e, ms[19:8]};
        in_lo    = {ms[7:0], c, ref_crc(e, m, c) ^ crc_flip};
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R7", {req, " busy"}, 64'(in_ready), 64'd0);
        chk(out_valid == 1'b0, "R7", {req, " early 1"}, 64'(out_valid), 64'd0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", {req, " early 2"}, 64'(out_valid), 64'd0);
        @(negedge clk);
        check_beat(e, ms, c, err, err ? 64'd0 : ref_lux(e, ms, sel), req);
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", {req, " single beat"}, 64'(out_valid), 64'd0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
    endtask

    task automatic test_patterns_a();
        run_sample(4'd0, 20'h00000, 4'd0, 4'd0, 20'd0, 1'b0, "R5 zero");
        run_sample(4'd3, 20'h12345, 4'd5, 4'd0, 20'd0, 1'b0, "R5 mid");
        run_sample(4'd7, 20'hABCDE, 4'd9, 4'd0, 20'd0, 1'b0, "R3 alt bits");
    endtask

    task automatic test_patterns_b();
        run_sample(4'd1, 20'h80808, 4'd2, 4'd0, 20'd0, 1'b1, "R5 pkg b");
        run_sample(4'd10, 20'h5A5A5, 4'd12, 4'd0, 20'd0, 1'b1, "R3 pkg b");
    endtask

    task automatic test_max();
        run_sample(4'd15, 20'hFFFFF, 4'd15, 4'd0, 20'd0, 1'b0, "R6 max a");
        run_sample(4'd15, 20'hFFFFF, 4'd15, 4'd0, 20'd0, 1'b1, "R6 max b");
    endtask

    task automatic test_crc_err();
        for (int b = 0; b < 4; b++)
            run_sample(4'd6, 20'h3C3C3, 4'd8, 4'(1 << b), 20'd0, 1'b0, "R4 crc bit");
        run_sample(4'd2, 20'h0F0F0, 4'd1, 4'd0, 20'h00100, 1'b1, "R4 mant flip");
    endtask

    task automatic test_busy_ignore();
        logic [3:0]  ea, eb, ca, cb;
        logic [19:0] ma, mb;
        ea = 4'd4; ma = 20'h24680; ca = 4'd3;
        eb = 4'd9; mb = 20'h13579; cb = 4'd11;
        @(negedge clk);
        pkg_sel  = 1'b0;
        in_valid = 1'b1;
        in_hi    = {ea, ma[19:8]};
        in_lo    = {ma[7:0], ca, ref_crc(ea, ma, ca)};
        @(negedge clk);
        in_hi = {eb, mb[19:8]};
        in_lo = {mb[7:0], cb, ref_crc(eb, mb, cb)};
        @(negedge clk);
        @(negedge clk);
        check_beat(ea, ma, ca, 1'b0, ref_lux(ea, ma, 1'b0), "R8 first");
        @(negedge clk);
        chk(in_ready == 1'b1, "R8", "idle returns", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R8", "no extra beat", 64'(out_valid), 64'd0);
        @(negedge clk);
        @(negedge clk);
        check_beat(eb, mb, cb, 1'b0, ref_lux(eb, mb, 1'b0), "R8 second");
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_patterns_a();
        test_patterns_b();
        test_max();
        test_crc_err();
        test_busy_ignore();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule